// File: doc/BRIEF.md
# Programmable Length Line Buffer

This block is a synchronous delay line for fixed-width samples whose length is set at run time. Every sample passes through an entry register, then a storage stage that is a circular memory of programmable length, then an exit register. The end-to-end latency is therefore the programmed length plus two register stages.

A mode input selects what feeds the entry register. In delay mode the data input feeds it, and each sample reappears unchanged after the programmed latency. In loop mode the exit register feeds it, so the data already inside keeps circulating as a circular store. The data input is then ignored. An active-low clock enable freezes every register and the memory. An active-low load strobe takes a new length value and restarts the storage pointer. Every register updates on the rising clock edge.

Top module: `lbuf_top`

## Requirements
- R1: A synchronous reset (`rst` high on an edge) clears `dout` to 0 and the length to 0. Until a length is loaded, a word sampled on enabled edge k is on `dout` after enabled edge k+1.
- R2: When an edge has `clk_en_n` low and `len_ld_n` low, that edge captures `len_in` as the length L for the following edges. When `clk_en_n` is high, the strobe and `len_in` have no effect.
- R3: In delay mode (`mode_sel` = 0), a word sampled from `din` on enabled edge k is on `dout` unchanged right after enabled edge k+L+1. This gives a total latency of L+2 register stages for every word of a continuous stream.
- R4: With L = 0 the memory is bypassed, and a word sampled on enabled edge k is on `dout` after enabled edge k+1.
- R5: With the largest length, L = 2^LEN_W-1, the latency is 2^LEN_W+1 stages, and the stream stays correct over several wraps of the pointer.
- R6: In loop mode (`mode_sel` = 1), `din` is ignored. The value on `dout` after enabled edge n equals the value after enabled edge n-(L+2), so the contents circulate with period L+2.
- R7: While `clk_en_n` is high, `dout` holds its value and no state advances. After `clk_en_n` goes low again, the stream continues as if the disabled edges had not occurred.
- R8: A load restarts the storage pointer. Counting enabled edges from 0 after the load edge, `dout` follows the new length from edge L+1 onward. Outputs before that are unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| mode_sel | input | 1 | 0 = delay mode, 1 = loop mode |
| len_in | input | LEN_W | Length value L to be loaded |
| len_ld_n | input | 1 | Length load strobe, active low |
| din | input | DATA_W | Sample input |
| dout | output | DATA_W | Sample output |

## Verification
The bench builds the block with DATA_W = 10 and LEN_W = 6. The memory then has 64 entries and the longest latency is 65 stages. With these values the maximum length, several complete pointer wraps at that length, and a long loop-mode run all fit in a few hundred cycles. The reload, stall and zero-length bypass cases run alongside, each against its own expected stream.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

    localparam int unsigned DATA_W_DEF = 10;
    localparam int unsigned LEN_W_DEF  = 11;

    // Source selection for the entry register
    typedef enum logic {
        MODE_DELAY = 1'b0,
        MODE_LOOP  = 1'b1
    } lbuf_mode_e;

    // Next position of a ring pointer of the given length (length 0 pins it at 0)
    function automatic logic [31:0] ring_step(input logic [31:0] cur, input logic [31:0] len);
        if (len == 32'd0 || cur + 32'd1 >= len) begin
            return 32'd0;
        end
        return cur + 32'd1;
    endfunction

endpackage

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl #(
    parameter int unsigned LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ld_n,
    input  logic [LEN_W-1:0] len_in,
    output logic [LEN_W-1:0] len_q,
    output logic [LEN_W-1:0] ptr_q
);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] ptr;
    } ctrl_t;

    ctrl_t       cur;
    ctrl_t       nxt;
    logic [31:0] step;

    always_comb begin
        nxt  = cur;
        step = lbuf_pkg::ring_step(32'(cur.ptr), 32'(cur.len));
        if (en) begin
            if (!ld_n) begin
                nxt.len = len_in;
                nxt.ptr = '0;
            end else begin
                nxt.ptr = step[LEN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign len_q = cur.len;
    assign ptr_q = cur.ptr;

    // R2: an enabled strobe captures the presented length
    a_r2_len_capture: assert property (@(posedge clk) disable iff (rst)
        (en && !ld_n) |=> (len_q == $past(len_in)));

    // R2: without enable the length cannot change
    a_r2_len_frozen: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> $stable(len_q));

    // R8: a load restarts the storage pointer
    a_r8_ptr_restart: assert property (@(posedge clk) disable iff (rst)
        (en && !ld_n) |=> (ptr_q == '0));

    // R3: the pointer always stays inside the programmed ring
    a_r3_ptr_in_ring: assert property (@(posedge clk) disable iff (rst)
        (len_q != '0) |-> (ptr_q < len_q));

endmodule

// File: rtl/lbuf_store.sv
module lbuf_store #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned LEN_W  = 11
) (
    input  logic              clk,
    input  logic              en,
    input  logic [LEN_W-1:0]  len_q,
    input  logic [LEN_W-1:0]  ptr_q,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << LEN_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] mem_rd;
    logic              bypass;

    assign bypass = (len_q == '0);
    assign mem_rd = mem[ptr_q];

    // The slot is read before it is overwritten, so each slot holds a word for L cycles
    always_ff @(posedge clk) begin
        if (en && !bypass) begin
            mem[ptr_q] <= wr_data;
        end
    end

    assign rd_data = bypass ? wr_data : mem_rd;

endmodule

// File: rtl/lbuf_top.sv
module lbuf_top
    import lbuf_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned LEN_W  = LEN_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              mode_sel,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              len_ld_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic [DATA_W-1:0] head;   // entry register
        logic [DATA_W-1:0] tail;   // exit register
    } pipe_t;

    logic              en;
    lbuf_mode_e        mode;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  ptr_q;
    logic [DATA_W-1:0] feed;
    logic [DATA_W-1:0] stage_out;
    pipe_t             pipe_q;
    pipe_t             pipe_d;

    assign en   = ~clk_en_n;
    assign mode = lbuf_mode_e'(mode_sel);

    lbuf_ctrl #(
        .LEN_W (LEN_W)
    ) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .ld_n   (len_ld_n),
        .len_in (len_in),
        .len_q  (len_q),
        .ptr_q  (ptr_q)
    );

    lbuf_store #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) store_i (
        .clk     (clk),
        .en      (en),
        .len_q   (len_q),
        .ptr_q   (ptr_q),
        .wr_data (pipe_q.head),
        .rd_data (stage_out)
    );

    always_comb begin
        feed   = (mode == MODE_LOOP) ? pipe_q.tail : din;
        pipe_d = pipe_q;
        if (en) begin
            pipe_d.head = feed;
            pipe_d.tail = stage_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q.tail;

    // R1: reset clears the output
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (dout == '0));

    // R7: a disabled edge leaves the output untouched
    a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(dout));

    // R4: at length zero the exit register takes the entry register directly
    a_r4_bypass_path: assert property (@(posedge clk) disable iff (rst)
        (en && len_q == '0) |=> (dout == $past(pipe_q.head)));

endmodule

// File: tb/lbuf_top_tb_top.sv
module lbuf_top_tb_top;

    localparam int unsigned DW   = 10;
    localparam int unsigned LW   = 6;
    localparam int          LMAX = (1 << LW) - 1;

    logic          clk      = 1'b0;
    logic          rst      = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          mode_sel = 1'b0;
    logic [LW-1:0] len_in   = '0;
    logic          len_ld_n = 1'b1;
    logic [DW-1:0] din      = '0;
    logic [DW-1:0] dout;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lbuf_top #(
        .DATA_W (DW),
        .LEN_W  (LW)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .clk_en_n (clk_en_n),
        .mode_sel (mode_sel),
        .len_in   (len_in),
        .len_ld_n (len_ld_n),
        .din      (din),
        .dout     (dout)
    );

    function automatic logic [DW-1:0] pat(input int i, input int seed);
        return DW'((i * 37 + seed * 101 + 5) % (1 << DW));
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout=%0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Inputs are set at a falling edge; one rising edge passes; sampling is at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input int L);
        len_in   = LW'(L);
        len_ld_n = 1'b0;
        step();
        len_ld_n = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        check("R1 reset", dout, '0);
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            din = pat(i, 1);
            step();
            if (i >= 1) check("R1 default length", dout, pat(i - 1, 1));
        end
    endtask

    task automatic t_stream(input string req, input int L, input int n, input int seed);
        mode_sel = 1'b0;
        do_load(L);
        for (int i = 0; i < n; i++) begin
            din = pat(i, seed);
            step();
            if (i >= L + 1) check(req, dout, pat(i - L - 1, seed));
        end
    endtask

    task automatic t_stall();
        logic [DW-1:0] held;
        mode_sel = 1'b0;
        do_load(3);
        for (int i = 0; i < 12; i++) begin
            din = pat(i, 7);
            step();
            if (i >= 4) check("R7 pre-stall", dout, pat(i - 4, 7));
        end
        held     = dout;
        clk_en_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            din      = ~pat(k, 9);
            len_in   = LW'(9);
            len_ld_n = 1'b0;
            step();
            check("R7 hold", dout, held);
        end
        clk_en_n = 1'b0;
        len_ld_n = 1'b1;
        for (int i = 12; i < 30; i++) begin
            din = pat(i, 7);
            step();
            check("R2 R7 resume", dout, pat(i - 4, 7));
        end
    endtask

    task automatic t_loop();
        logic [DW-1:0] x [256];
        int L;
        int s;
        L = 4;
        s = 3 * (L + 2);
        mode_sel = 1'b0;
        do_load(L);
        for (int i = 0; i < s; i++) begin
            din  = pat(i, 3);
            x[i] = pat(i, 3);
            step();
            if (i >= L + 1) check("R6 fill", dout, x[i - L - 1]);
        end
        mode_sel = 1'b1;
        for (int i = s; i < s + 40; i++) begin
            din  = ~pat(i, 11);
            x[i] = x[i - L - 2];
            step();
            check("R6 loop", dout, x[i - L - 1]);
        end
        mode_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_stream("R3 L=5", 5, 30, 2);
        t_stream("R3 L=17", 17, 60, 4);
        t_stream("R4 L=0", 0, 20, 5);
        t_stream("R5 Lmax", LMAX, 3 * LMAX + 10, 6);
        t_stall();
        t_loop();
        t_stream("R8 before reload", 9, 25, 8);
        t_stream("R8 after reload", 2, 20, 10);
        finish_run();
    end

endmodule